// File: doc/BRIEF.md
# Configuration Retry Supervisor

This block decides where and when a flash-to-FPGA configuration loader begins reading. Each configuration attempt starts with a one-cycle start pulse and a flash byte address. The loader then reports either success or failure. A failure is handled by one of three policies:

- stop and wait for help;
- read again from the start of the page that failed;
- jump to a fixed recovery address set at build time.

A synchronized, edge-detected reconfigure request, active low, starts a fresh attempt. It does so from the configured state and from the halted state, using the page currently selected on the `pageSel` input.

While the device is running its configured image, a watchdog counts system clock cycles. If software does not kick it within the timeout, it raises a sticky error. That is the hook a remote-upgrade scheme uses to detect a bad image.

The block also produces the enable for the serial configuration clock. The enable runs at one, two, four or eight system clocks per configuration clock cycle. The flash reads and the bitstream shifting live in neighbouring blocks.

Top module: `config_retry_supervisor`

## Requirements
- R1: During reset `startPulse`, `configured`, `halted` and `wdErr` are low. After reset is released, an attempt starts on its own, with `startAddr = {pageSel, zeros}`; `pageSel` forms the top PAGE_W bits of the ADDR_W-bit address.
- R2: `startPulse` is high for exactly one cycle per attempt, and the address is valid in that cycle.
- R3: If the loader reports done (without an error) while an attempt is in flight, `configured` rises on the next cycle and no further attempt starts on its own.
- R4: If failure policy 2'b00 or 2'b11 (halt) is selected when an error is reported, `halted` rises and no attempt starts until a reconfigure request arrives.
- R5: Under policy 2'b01 (same page), an error starts a new attempt at the start of the page of the failed attempt, whatever `pageSel` shows at that time.
- R6: Under policy 2'b10 (fixed), an error starts a new attempt at the byte address FIXED_ADDR.
- R7: If done and error are reported in the same cycle, the error wins.
- R8: A falling edge on `nReconfig`, taken through a two-flop synchronizer, starts exactly one attempt from the current `pageSel`, from either the configured or the halted state. A level held low starts no second attempt.
- R9: A reconfigure edge that arrives while an attempt is in flight is dropped.
- R10: In the configured state the watchdog sets `wdErr` after WDOG_CYCLES consecutive cycles without a kick. `wdErr` then stays high.
- R11: A cycle with `wdKick` high clears `wdErr` on the next cycle and restarts the count.
- R12: The `clkRatio` codes 0, 1, 2 and 3 select N = 1, 2, 4 and 8. With N = 1, `dclkEn` is high every cycle. Otherwise it is a single-cycle pulse exactly every N cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pageSel | input | PAGE_W | Page used by reset-time and reconfigure attempts |
| failMode | input | 2 | Failure policy: 00/11 halt, 01 same page, 10 fixed address |
| clkRatio | input | 2 | Configuration clock division code (N = 2^code) |
| nReconfig | input | 1 | Asynchronous reconfigure request, active low |
| wdKick | input | 1 | Watchdog restart |
| cfgDone | input | 1 | Loader reports a successful configuration |
| cfgErr | input | 1 | Loader reports a configuration failure |
| startPulse | output | 1 | One-cycle attempt start |
| startAddr | output | ADDR_W | Flash byte address for the attempt |
| configured | output | 1 | Target device is configured |
| halted | output | 1 | Stopped after a failure under the halt policy |
| wdErr | output | 1 | Sticky watchdog timeout |
| dclkEn | output | 1 | Configuration clock enable |

## Verification
On every cycle, the assertions check four things:

- a start pulse never lasts two cycles;
- the halted state starts nothing;
- each policy, given an error while waiting, leads to the right next state or address;
- the watchdog error rises only out of the configured state and always falls after a kick.

The pulse spacing of the clock enable is checked whenever the ratio is above one. Other behaviour spans many cycles and needs the bench's scenarios:

- a same-page retry must use the page latched at the earlier start rather than the current input;
- a held-low reconfigure must start only once;
- an edge during an attempt must vanish;
- the exact timeout length and the pulse count per ratio.

// File: rtl/cfg_sup_pkg.sv
package cfg_sup_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LOAD = 3'd1,
    ST_WAIT = 3'd2,
    ST_DONE = 3'd3,
    ST_HALT = 3'd4
  } supState_t;

  localparam logic [1:0] POL_HALT  = 2'b00;
  localparam logic [1:0] POL_SAME  = 2'b01;
  localparam logic [1:0] POL_FIXED = 2'b10;

  // strobes from control to datapath
  typedef struct packed {
    logic takePage;   // load address from pageSel
    logic takeSame;   // reload start of the latched page
    logic takeFixed;  // load the recovery address
    logic wdRun;      // watchdog may count
  } supStrobe_t;

endpackage

// File: rtl/cfg_sup_clkdiv.sv
module cfg_sup_clkdiv #(
  parameter int MAX_RATIO_LOG = 3
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic [$clog2(MAX_RATIO_LOG+1)-1:0]    clkRatio,
  output logic                                  dclkEn
);
  localparam int CNT_W = (MAX_RATIO_LOG < 1) ? 1 : MAX_RATIO_LOG;

  logic [CNT_W-1:0] divCnt;
  logic [CNT_W-1:0] divMask;

  always_comb divMask = CNT_W'((32'd1 << clkRatio) - 32'd1);

  always_ff @(posedge clk) begin
    if (rst) divCnt <= '0;
    else if (divCnt >= divMask) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end

  assign dclkEn = (divCnt == divMask);
endmodule

// File: rtl/cfg_sup_ctrl.sv
module cfg_sup_ctrl
  import cfg_sup_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] failMode,
  input  logic       cfgDone,
  input  logic       cfgErr,
  input  logic       reconfPulse,
  output supState_t  stateQ,
  output supStrobe_t strobe,
  output logic       startPulse,
  output logic       configured,
  output logic       halted
);
  supState_t stateNxt;

  always_comb begin
    stateNxt = stateQ;
    strobe   = '0;
    unique case (stateQ)
      ST_IDLE: begin
        stateNxt        = ST_LOAD;
        strobe.takePage = 1'b1;
      end
      ST_LOAD: stateNxt = ST_WAIT;
      ST_WAIT: begin
        if (cfgErr) begin
          unique case (failMode)
            POL_SAME: begin
              stateNxt        = ST_LOAD;
              strobe.takeSame = 1'b1;
            end
            POL_FIXED: begin
              stateNxt         = ST_LOAD;
              strobe.takeFixed = 1'b1;
            end
            default: stateNxt = ST_HALT;
          endcase
        end else if (cfgDone) begin
          stateNxt = ST_DONE;
        end
      end
      ST_DONE, ST_HALT: begin
        if (reconfPulse) begin
          stateNxt        = ST_LOAD;
          strobe.takePage = 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
    strobe.wdRun = (stateQ == ST_DONE);
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_IDLE;
    else     stateQ <= stateNxt;
  end

  assign startPulse = (stateQ == ST_LOAD);
  assign configured = (stateQ == ST_DONE);
  assign halted     = (stateQ == ST_HALT);
endmodule

// File: rtl/cfg_sup_dpath.sv
module cfg_sup_dpath
  import cfg_sup_pkg::*;
#(
  parameter int                ADDR_W      = 24,
  parameter int                PAGE_W      = 3,
  parameter logic [ADDR_W-1:0] FIXED_ADDR  = 24'h024000,
  parameter int                WDOG_CYCLES = 5_000_000,
  parameter bit                WDOG_EN     = 1'b1,
  parameter bit                RECONF_EN   = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PAGE_W-1:0] pageSel,
  input  logic              nReconfig,
  input  logic              wdKick,
  input  supStrobe_t        strobe,
  output logic [ADDR_W-1:0] startAddr,
  output logic              reconfPulse,
  output logic              wdErr
);
  localparam int OFS_W = ADDR_W - PAGE_W;

  logic [PAGE_W-1:0] pageQ;
  logic [ADDR_W-1:0] addrQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      pageQ <= '0;
      addrQ <= '0;
    end else if (strobe.takePage) begin
      pageQ <= pageSel;
      addrQ <= {pageSel, {OFS_W{1'b0}}};
    end else if (strobe.takeSame) begin
      addrQ <= {pageQ, {OFS_W{1'b0}}};
    end else if (strobe.takeFixed) begin
      pageQ <= FIXED_ADDR[ADDR_W-1 -: PAGE_W];
      addrQ <= FIXED_ADDR;
    end
  end
  assign startAddr = addrQ;

  generate
    if (RECONF_EN) begin : g_reconf
      logic [2:0] syncQ;
      always_ff @(posedge clk) begin
        if (rst) syncQ <= 3'b111;
        else     syncQ <= {syncQ[1:0], nReconfig};
      end
      assign reconfPulse = syncQ[2] & ~syncQ[1];
    end else begin : g_noreconf
      assign reconfPulse = 1'b0;
    end

    if (WDOG_EN) begin : g_wd
      localparam int WD_W = $clog2(WDOG_CYCLES + 1);
      logic [WD_W-1:0] wdCnt;
      logic            errQ;
      always_ff @(posedge clk) begin
        if (rst || wdKick) begin
          wdCnt <= '0;
          errQ  <= 1'b0;
        end else if (!strobe.wdRun) begin
          wdCnt <= '0;
        end else if (wdCnt == WD_W'(WDOG_CYCLES - 1)) begin
          errQ  <= 1'b1;
        end else begin
          wdCnt <= wdCnt + 1'b1;
        end
      end
      assign wdErr = errQ;
    end else begin : g_nowd
      assign wdErr = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/config_retry_supervisor.sv
module config_retry_supervisor
  import cfg_sup_pkg::*;
#(
  parameter int                ADDR_W        = 24,
  parameter int                PAGE_W        = 3,
  parameter logic [ADDR_W-1:0] FIXED_ADDR    = 24'h024000,
  parameter int                CLK_HZ        = 50_000_000,
  parameter int                TIMEOUT_MS    = 100,
  parameter int                WDOG_CYCLES   = CLK_HZ / 1000 * TIMEOUT_MS,
  parameter bit                WDOG_EN       = 1'b1,
  parameter bit                RECONF_EN     = 1'b1,
  parameter int                MAX_RATIO_LOG = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PAGE_W-1:0] pageSel,
  input  logic [1:0]        failMode,
  input  logic [1:0]        clkRatio,
  input  logic              nReconfig,
  input  logic              wdKick,
  input  logic              cfgDone,
  input  logic              cfgErr,
  output logic              startPulse,
  output logic [ADDR_W-1:0] startAddr,
  output logic              configured,
  output logic              halted,
  output logic              wdErr,
  output logic              dclkEn
);
  supState_t  stateQ;
  supStrobe_t strobe;
  logic       reconfPulse;

  cfg_sup_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .failMode    (failMode),
    .cfgDone     (cfgDone),
    .cfgErr      (cfgErr),
    .reconfPulse (reconfPulse),
    .stateQ      (stateQ),
    .strobe      (strobe),
    .startPulse  (startPulse),
    .configured  (configured),
    .halted      (halted)
  );

  cfg_sup_dpath #(
    .ADDR_W      (ADDR_W),
    .PAGE_W      (PAGE_W),
    .FIXED_ADDR  (FIXED_ADDR),
    .WDOG_CYCLES (WDOG_CYCLES),
    .WDOG_EN     (WDOG_EN),
    .RECONF_EN   (RECONF_EN)
  ) u_dpath (
    .clk         (clk),
    .rst         (rst),
    .pageSel     (pageSel),
    .nReconfig   (nReconfig),
    .wdKick      (wdKick),
    .strobe      (strobe),
    .startAddr   (startAddr),
    .reconfPulse (reconfPulse),
    .wdErr       (wdErr)
  );

  cfg_sup_clkdiv #(
    .MAX_RATIO_LOG (MAX_RATIO_LOG)
  ) u_clkdiv (
    .clk      (clk),
    .rst      (rst),
    .clkRatio (clkRatio),
    .dclkEn   (dclkEn)
  );
endmodule

// File: rtl/cfg_sup_chk.sv
module cfg_sup_chk
  import cfg_sup_pkg::*;
#(
  parameter int                ADDR_W     = 24,
  parameter logic [ADDR_W-1:0] FIXED_ADDR = 24'h024000
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        failMode,
  input logic [1:0]        clkRatio,
  input logic              cfgDone,
  input logic              cfgErr,
  input logic              wdKick,
  input logic              startPulse,
  input logic [ADDR_W-1:0] startAddr,
  input logic              configured,
  input logic              halted,
  input logic              wdErr,
  input logic              dclkEn,
  input supState_t         stateQ
);
  // R2
  start_single_chk: assert property (@(posedge clk) disable iff (rst)
    startPulse |=> !startPulse);

  // R3
  done_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_WAIT && cfgDone && !cfgErr) |=> configured);

  // R4
  halt_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_WAIT && cfgErr && (failMode == POL_HALT || failMode == 2'b11)) |=> halted);

  // R4
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> !startPulse);

  // R6 R7
  fixed_retry_chk: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_WAIT && cfgErr && failMode == POL_FIXED) |=> (startPulse && startAddr == FIXED_ADDR));

  // R5
  same_retry_chk: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_WAIT && cfgErr && failMode == POL_SAME) |=> startPulse);

  // R10
  wd_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wdErr) |-> $past(configured));

  // R11
  kick_clear_chk: assert property (@(posedge clk) disable iff (rst)
    wdKick |=> !wdErr);

  // R12
  dclk_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (dclkEn && clkRatio != 2'd0) |=> (!dclkEn || clkRatio == 2'd0));
endmodule

bind config_retry_supervisor cfg_sup_chk #(
  .ADDR_W     (ADDR_W),
  .FIXED_ADDR (FIXED_ADDR)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .failMode   (failMode),
  .clkRatio   (clkRatio),
  .cfgDone    (cfgDone),
  .cfgErr     (cfgErr),
  .wdKick     (wdKick),
  .startPulse (startPulse),
  .startAddr  (startAddr),
  .configured (configured),
  .halted     (halted),
  .wdErr      (wdErr),
  .dclkEn     (dclkEn),
  .stateQ     (stateQ)
);

// File: tb/config_retry_supervisor_test.sv
module config_retry_supervisor_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;
  localparam int PW = 3;
  localparam logic [AW-1:0] FIX = 24'h024000;
  localparam int WD = 40;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          rst = 1'b1;
  logic [PW-1:0] pageSel = 3'd5;
  logic [1:0]    failMode = 2'b01;
  logic [1:0]    clkRatio = 2'd0;
  logic          nReconfig = 1'b1;
  logic          wdKick = 1'b0;
  logic          cfgDone = 1'b0;
  logic          cfgErr = 1'b0;
  logic          startPulse, configured, halted, wdErr, dclkEn;
  logic [AW-1:0] startAddr;

  int nChecks = 0;
  int nFails  = 0;

  config_retry_supervisor #(
    .ADDR_W(AW), .PAGE_W(PW), .FIXED_ADDR(FIX), .WDOG_CYCLES(WD)
  ) uut (
    .clk(clk), .rst(rst), .pageSel(pageSel), .failMode(failMode),
    .clkRatio(clkRatio), .nReconfig(nReconfig), .wdKick(wdKick),
    .cfgDone(cfgDone), .cfgErr(cfgErr), .startPulse(startPulse),
    .startAddr(startAddr), .configured(configured), .halted(halted),
    .wdErr(wdErr), .dclkEn(dclkEn)
  );

  function automatic logic [AW-1:0] pageAddr(input logic [PW-1:0] p);
    return {p, {(AW-PW){1'b0}}};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    summary();
  end

  // leaves the bench at the negedge after the pulse (attempt waiting)
  task automatic expectStart(input logic [AW-1:0] exp, input string req);
    bit seen = 0;
    for (int i = 0; i < 8; i++) begin
      if (startPulse) begin seen = 1; break; end
      @(negedge clk);
    end
    chk(seen, req, seen, 1);
    chk(startAddr == exp, req, startAddr, exp);
    @(negedge clk);
    chk(!startPulse, "R2", startPulse, 0);
  endtask

  task automatic respond(input bit d, input bit e);
    cfgDone = d;
    cfgErr  = e;
    @(negedge clk);
    cfgDone = 1'b0;
    cfgErr  = 1'b0;
  endtask

  task automatic countStarts(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (startPulse) c++;
    end
  endtask

  task automatic pulseReconf();
    nReconfig = 1'b0;
    repeat (2) @(negedge clk);
    nReconfig = 1'b1;
  endtask

  initial begin
    int c;
    logic [AW-1:0] exp;
    void'($urandom(32'd4242));

    // R1 reset state
    repeat (4) @(negedge clk);
    chk(!startPulse && !configured && !halted && !wdErr, "R1",
        {startPulse, configured, halted, wdErr}, 0);
    rst = 1'b0;
    expectStart(pageAddr(3'd5), "R1");

    // R5 same page, pageSel moved after the start
    pageSel  = 3'd2;
    failMode = 2'b01;
    respond(0, 1);
    expectStart(pageAddr(3'd5), "R5");

    // R6 fixed address
    failMode = 2'b10;
    respond(0, 1);
    expectStart(FIX, "R6");

    // R5 same page after a fixed attempt
    failMode = 2'b01;
    respond(0, 1);
    expectStart(pageAddr(FIX[AW-1 -: PW]), "R5");

    // R7 error wins over done
    failMode = 2'b10;
    respond(1, 1);
    chk(!configured, "R7", configured, 0);
    expectStart(FIX, "R7");

    // R3 done
    respond(1, 0);
    chk(configured, "R3", configured, 1);
    countStarts(10, c);
    chk(c == 0, "R3", c, 0);

    // R10 R11 watchdog
    wdKick = 1'b1;
    @(negedge clk);
    wdKick = 1'b0;
    chk(!wdErr, "R11", wdErr, 0);
    repeat (WD - 1) @(negedge clk);
    chk(!wdErr, "R10", wdErr, 0);
    @(negedge clk);
    chk(wdErr, "R10", wdErr, 1);
    repeat (10) @(negedge clk);
    chk(wdErr, "R10", wdErr, 1);
    wdKick = 1'b1;
    @(negedge clk);
    wdKick = 1'b0;
    chk(!wdErr, "R11", wdErr, 0);
    repeat (WD - 1) @(negedge clk);
    chk(!wdErr, "R11", wdErr, 0);

    // R8 held low starts once
    pageSel   = 3'd6;
    nReconfig = 1'b0;
    expectStart(pageAddr(3'd6), "R8");
    countStarts(20, c);
    chk(c == 0, "R8", c, 0);
    respond(1, 0);
    countStarts(10, c);
    chk(c == 0 && configured, "R8", c, 0);
    nReconfig = 1'b1;
    repeat (4) @(negedge clk);

    // R9 edge during an attempt is dropped
    pageSel = 3'd1;
    pulseReconf();
    expectStart(pageAddr(3'd1), "R8");
    pulseReconf();
    countStarts(8, c);
    chk(c == 0, "R9", c, 0);
    respond(1, 0);
    chk(configured, "R9", configured, 1);
    countStarts(6, c);
    chk(c == 0, "R9", c, 0);

    // R4 halt, then recovery through reconfigure
    pageSel = 3'd3;
    pulseReconf();
    expectStart(pageAddr(3'd3), "R8");
    failMode = 2'b00;
    respond(0, 1);
    chk(halted, "R4", halted, 1);
    countStarts(15, c);
    chk(c == 0 && halted, "R4", c, 0);
    pageSel = 3'd7;
    pulseReconf();
    expectStart(pageAddr(3'd7), "R4");
    respond(1, 0);

    // random phase
    for (int it = 0; it < 40; it++) begin
      pageSel = PW'($urandom);
      pulseReconf();
      exp = pageAddr(pageSel);
      for (int k = 0; k < 6; k++) begin
        int oc;
        int mode;
        string tag;
        tag = (k == 0) ? "R8" : ((exp == FIX) ? "R6" : "R5");
        expectStart(exp, tag);
        pageSel = PW'($urandom);
        oc = (k == 5) ? 0 : int'($urandom % 4);
        if (oc == 0) begin
          respond(1, 0);
          chk(configured, "R3", configured, 1);
          break;
        end
        mode = int'($urandom % 4);
        failMode = 2'(mode);
        respond(oc == 3, 1);
        if (mode == 1) exp = pageAddr(exp[AW-1 -: PW]);
        else if (mode == 2) exp = FIX;
        else begin
          chk(halted, "R4", halted, 1);
          countStarts(5, c);
          chk(c == 0, "R4", c, 0);
          break;
        end
      end
    end

    // R12 clock enable per ratio
    for (int code = 0; code < 4; code++) begin
      int n;
      int cnt;
      int last;
      int bad;
      n = 1 << code;
      clkRatio = 2'(code);
      repeat (10) @(negedge clk);
      cnt = 0;
      last = -1;
      bad = 0;
      for (int i = 0; i < 64; i++) begin
        if (dclkEn) begin
          if (last >= 0 && i - last != n) bad++;
          last = i;
          cnt++;
        end
        @(negedge clk);
      end
      chk(cnt == 64 / n, "R12", cnt, 64 / n);
      chk(bad == 0, "R12", bad, 0);
    end

    summary();
  end
endmodule